// File: doc/BRIEF.md
# Configuration Byte Bank with One-Time-Programmable Shadow

This block holds the configuration of a power-management device. Three configuration bytes each exist in two copies: a volatile working copy (REG) written over the serial control bus, and a one-time-programmable image (OTP) that is loaded at power-up. A command register holds one select bit per byte. That bit decides which copy drives the active configuration and which copy a read of the byte's address returns. The select bits come up cleared, so the device always starts from the OTP image. Software can stage new values in REG, try them by setting the select bits, and then make them permanent with a program command. The program command only takes effect while a programming-voltage-present input is high.

The block sits behind a serial slave that supplies a one-cycle write strobe with address and data, and a combinational read port. Shutdown and lockout (undervoltage or thermal) inputs clear the command register. A non-volatile lock bit can be burned together with a program command. Once set, it freezes the configuration, while the command register's reset and switch-off bits keep working. The active sequencing field is decoded into a mode output and an outputs-off flag.

Top module: `cfgbank_top`

## Requirements
- R1: Command register bit i (i = 0..2, at address 3) selects the source of byte i. With the bit at 0, the OTP byte drives `active_cfg_o[8i+7:8i]` and a read of address i. With the bit at 1, the REG byte does.
- R2: A write to address 0..2 updates only the REG byte at that address. The OTP image changes only in the cycle that `prog_pulse_o` is high.
- R3: While `shutdown_i` is high, the whole command register, select bits included, is cleared to zero the cycle after. All writes are ignored during shutdown.
- R4: The command register is 00h after reset, and is cleared while `lockout_i` is high.
- R5: REG bytes have no reset and keep their last written value through shutdown and lockout.
- R6: When command bit 3 (write-OTP) is set and `vpp_ok_i` is high, `prog_pulse_o` goes high for one cycle on the next clock edge and the OTP image takes the REG bytes. Without `vpp_ok_i` the request stays pending and no pulse is issued.
- R7: The write-OTP bit, and the burn-lock bit (command bit 4), self-clear on the edge after the pulse. `prog_pulse_o` is never high in two consecutive cycles.
- R8: A program pulse with burn-lock set sets the non-volatile lock, which reads back as command bit 7. While locked, REG writes and writes to command bits 0..4 are ignored, and no program pulse is issued.
- R9: Under lock, writing command bit 5 (reset) clears command bits 0..6. Command bit 6 (switch-off) is still writable and drives `swoff_o`.
- R10: Address 3 reads the command register with the lock in bit 7. Addresses 4..7 read 00h.
- R11: `seq_mode_o` is bits 1:0 of active byte 2, and `outputs_off_o` is high when that field is 00. An all-zero OTP image therefore yields outputs off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low power-up reset |
| shutdown_i | input | 1 | Shutdown; clears command register, blocks writes |
| lockout_i | input | 1 | Undervoltage/thermal lockout; clears command register, blocks writes |
| vpp_ok_i | input | 1 | Programming voltage present |
| wr_en_i | input | 1 | One-cycle write strobe from the bus slave |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| active_cfg_o | output | 24 | Active configuration bytes, byte i at bits 8i+7:8i |
| seq_mode_o | output | 2 | Active power-up sequencing field |
| outputs_off_o | output | 1 | Sequencing field is 00 |
| swoff_o | output | 1 | Switch-off command bit |
| prog_pulse_o | output | 1 | One-cycle OTP program pulse |

## Verification
The assertions assume that `shutdown_i`, `lockout_i` and `vpp_ok_i` are synchronous to the clock. They also assume that a REG byte is written before its select bit is set, since REG bytes come up unknown. The stimulus loads all three REG bytes before it touches any select bit. It changes level inputs and write strobes only at falling edges. It lets every program request finish before it issues the next command write, so the self-clear of the write-OTP bit is never overlapped by a new write.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  typedef logic [7:0] cfg_byte_t;

  localparam int LOCK_RB_BIT = 7;

  // choose the visible copy of one configuration byte
  function automatic cfg_byte_t pick_copy(input logic use_reg, input cfg_byte_t otp_b,
                                          input cfg_byte_t reg_b);
    return use_reg ? reg_b : otp_b;
  endfunction

  // sequencing field of a configuration byte
  function automatic logic [1:0] seq_field(input cfg_byte_t b);
    return b[1:0];
  endfunction

endpackage

// File: rtl/cfgbank_regs.sv
module cfgbank_regs #(
  parameter int NBYTES = 3,
  parameter int AW     = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_ok_i,
  input  logic                        wr_en_i,
  input  logic [AW-1:0]               wr_addr_i,
  input  logic [7:0]                  wr_data_i,
  input  logic                        lock_i,
  output logic [NBYTES-1:0][7:0]      regs_o
);

  logic [NBYTES-1:0][7:0] regs_q;
  logic                   reg_wr_allowed;

  assign reg_wr_allowed = wr_en_i && wr_ok_i && !lock_i;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [AW-1:0] MY_ADDR = AW'(i);
    // no reset: working copy keeps its contents across shutdown
    always_ff @(posedge clk_i) begin
      if (reg_wr_allowed && wr_addr_i == MY_ADDR) regs_q[i] <= wr_data_i;
    end
  end

  assign regs_o = regs_q;

  AST_REG_FROZEN_UNDER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni) lock_i |=> $stable(regs_q)); // R8

endmodule

// File: rtl/cfgbank_nvm.sv
module cfgbank_nvm #(
  parameter int                  NBYTES    = 3,
  parameter logic [NBYTES*8-1:0] OTP_INIT  = '0,
  parameter logic                LOCK_INIT = 1'b0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wotp_i,
  input  logic                   burn_i,
  input  logic                   vpp_ok_i,
  input  logic [NBYTES-1:0][7:0] regs_i,
  output logic [NBYTES-1:0][7:0] otp_o,
  output logic                   lock_o,
  output logic                   pulse_o
);

  logic [NBYTES-1:0][7:0] otp_q;
  logic                   lock_q;
  logic                   pulse_q;
  logic                   fire;

  // program request accepted: supply present, not locked, not just programmed
  assign fire = wotp_i && vpp_ok_i && !lock_q && !pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      otp_q   <= OTP_INIT;
      lock_q  <= LOCK_INIT;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (fire) begin
        otp_q  <= regs_i;
        lock_q <= lock_q | burn_i;
      end
    end
  end

  assign otp_o   = otp_q;
  assign lock_o  = lock_q;
  assign pulse_o = pulse_q;

  AST_OTP_ONLY_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) (otp_q != $past(otp_q)) |-> pulse_q); // R2
  AST_PULSE_NEEDS_VPP: assert property (@(posedge clk_i) disable iff (!rst_ni) pulse_q |-> $past(vpp_ok_i)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) pulse_q |=> !pulse_q); // R7
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) lock_q |=> lock_q); // R8
  AST_LOCKED_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) (lock_q && !pulse_q) |=> !pulse_q); // R8

endmodule

// File: rtl/cfgbank_cmd.sv
module cfgbank_cmd #(
  parameter int NBYTES = 3,
  parameter int AW     = 3,
  localparam int WOTP_B  = NBYTES,
  localparam int BURN_B  = NBYTES + 1,
  localparam int RST_B   = NBYTES + 2,
  localparam int SWOFF_B = NBYTES + 3,
  localparam int CMDW    = NBYTES + 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  logic            lock_i,
  input  logic            prog_pulse_i,
  output logic [CMDW-1:0] cmd_o
);

  localparam logic [AW-1:0] CMD_ADDR = AW'(NBYTES);

  logic [CMDW-1:0] cmd_q;
  logic [CMDW-1:0] cmd_d;
  logic            cmd_wr;
  logic            unused_hi;

  assign cmd_wr    = wr_en_i && (wr_addr_i == CMD_ADDR);
  assign unused_hi = ^wr_data_i[7:CMDW];

  always_comb begin
    cmd_d = cmd_q;
    if (clear_i) begin
      cmd_d = '0;
    end else if (cmd_wr) begin
      if (wr_data_i[RST_B]) begin
        cmd_d = '0;
      end else begin
        cmd_d[SWOFF_B] = wr_data_i[SWOFF_B];
        if (!lock_i) begin
          cmd_d[NBYTES-1:0] = wr_data_i[NBYTES-1:0];
          cmd_d[WOTP_B]     = wr_data_i[WOTP_B];
          cmd_d[BURN_B]     = wr_data_i[BURN_B];
        end
      end
    end else if (prog_pulse_i) begin
      cmd_d[WOTP_B] = 1'b0;
      cmd_d[BURN_B] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else         cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;

  AST_CLEAR_EMPTIES_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni) clear_i |=> (cmd_q == '0)); // R3
  AST_WOTP_SELF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) (prog_pulse_i && !cmd_wr) |=> !cmd_q[WOTP_B]); // R7
  AST_LOCK_KEEPS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni) (lock_i && !clear_i && !(cmd_wr && wr_data_i[RST_B])) |=> (cmd_q[NBYTES-1:0] == $past(cmd_q[NBYTES-1:0]))); // R8

endmodule

// File: rtl/cfgbank_view.sv
module cfgbank_view #(
  parameter int NBYTES = 3,
  parameter int AW     = 3,
  parameter int CMDW   = NBYTES + 4
) (
  input  logic [NBYTES-1:0][7:0] otp_i,
  input  logic [NBYTES-1:0][7:0] regs_i,
  input  logic [CMDW-1:0]        cmd_i,
  input  logic                   lock_i,
  input  logic [AW-1:0]          rd_addr_i,
  output logic [NBYTES-1:0][7:0] active_o,
  output logic [7:0]             rd_data_o
);
  import cfgbank_pkg::*;

  localparam logic [AW-1:0] CMD_ADDR = AW'(NBYTES);

  logic [7:0] cmd_rb;

  for (genvar i = 0; i < NBYTES; i++) begin : g_pick
    assign active_o[i] = pick_copy(cmd_i[i], otp_i[i], regs_i[i]);
  end

  always_comb begin
    cmd_rb              = '0;
    cmd_rb[CMDW-1:0]    = cmd_i;
    cmd_rb[LOCK_RB_BIT] = lock_i;
  end

  // readback follows the same per-byte select as the active copy
  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == CMD_ADDR) begin
      rd_data_o = cmd_rb;
    end else begin
      for (int i = 0; i < NBYTES; i++) begin
        if (rd_addr_i == AW'(i)) rd_data_o = active_o[i];
      end
    end
  end

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top #(
  parameter int                  NBYTES    = 3,
  parameter int                  AW        = 3,
  parameter logic [NBYTES*8-1:0] OTP_INIT  = '0,
  parameter logic                LOCK_INIT = 1'b0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shutdown_i,
  input  logic                  lockout_i,
  input  logic                  vpp_ok_i,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic [NBYTES*8-1:0]   active_cfg_o,
  output logic [1:0]            seq_mode_o,
  output logic                  outputs_off_o,
  output logic                  swoff_o,
  output logic                  prog_pulse_o
);
  import cfgbank_pkg::*;

  localparam int CMDW     = NBYTES + 4;
  localparam int WOTP_B   = NBYTES;
  localparam int BURN_B   = NBYTES + 1;
  localparam int SWOFF_B  = NBYTES + 3;
  localparam int SEQ_BYTE = NBYTES - 1;

  logic                   clear_cmd;
  logic                   wr_ok;
  logic [CMDW-1:0]        cmd;
  logic                   lock;
  logic [NBYTES-1:0][7:0] regs;
  logic [NBYTES-1:0][7:0] otp;
  logic [NBYTES-1:0][7:0] active;

  assign clear_cmd = shutdown_i || lockout_i;
  assign wr_ok     = !clear_cmd;

  cfgbank_regs #(.NBYTES(NBYTES), .AW(AW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_ok_i(wr_ok), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .lock_i(lock), .regs_o(regs)
  );

  cfgbank_cmd #(.NBYTES(NBYTES), .AW(AW)) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_cmd), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .lock_i(lock),
    .prog_pulse_i(prog_pulse_o), .cmd_o(cmd)
  );

  cfgbank_nvm #(.NBYTES(NBYTES), .OTP_INIT(OTP_INIT), .LOCK_INIT(LOCK_INIT)) u_nvm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wotp_i(cmd[WOTP_B]), .burn_i(cmd[BURN_B]),
    .vpp_ok_i(vpp_ok_i), .regs_i(regs), .otp_o(otp), .lock_o(lock), .pulse_o(prog_pulse_o)
  );

  cfgbank_view #(.NBYTES(NBYTES), .AW(AW), .CMDW(CMDW)) u_view (
    .otp_i(otp), .regs_i(regs), .cmd_i(cmd), .lock_i(lock), .rd_addr_i(rd_addr_i),
    .active_o(active), .rd_data_o(rd_data_o)
  );

  assign active_cfg_o  = active;
  assign seq_mode_o    = seq_field(active[SEQ_BYTE]);
  assign outputs_off_o = (seq_mode_o == 2'b00);
  assign swoff_o       = cmd[SWOFF_B];

  AST_SHDN_DROPS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni) shutdown_i |=> (active == otp)); // R3
  AST_OFF_FLAG_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni) outputs_off_o |-> (active_cfg_o[SEQ_BYTE*8 +: 2] == 2'b00)); // R11

endmodule

// File: tb/cfgbank_top_bench.sv
`timescale 1ns/1ps
module cfgbank_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shutdown = 1'b0, lockout = 1'b0, vpp = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [23:0] active;
  logic [1:0]  seq_mode;
  logic        outs_off, swoff, pulse;

  int n_chk = 0, n_fail = 0, pulse_cnt = 0;
  logic [7:0] m_reg [3];
  logic [7:0] m_otp [3];
  logic [2:0] m_sel;

  always #4 clk = ~clk;

  cfgbank_top u_cfgbank_top (
    .clk_i(clk), .rst_ni(rst_n), .shutdown_i(shutdown), .lockout_i(lockout),
    .vpp_ok_i(vpp), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .active_cfg_o(active),
    .seq_mode_o(seq_mode), .outputs_off_o(outs_off), .swoff_o(swoff), .prog_pulse_o(pulse)
  );

  always @(negedge clk) if (rst_n && pulse) pulse_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    return m_sel[i] ? m_reg[i] : m_otp[i];
  endfunction

  task automatic chk_view(input string tag);
    logic [23:0] e;
    for (int i = 0; i < 3; i++) begin
      rd_chk(tag, 3'(i), exp_byte(i));
      e[i*8 +: 8] = exp_byte(i);
    end
    chk({tag, " active"}, active, e);
    chk({tag, " seq"}, seq_mode, e[17:16]);
    chk({tag, " off"}, outs_off, e[17:16] == 2'b00);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 3; i++) m_otp[i] = 8'h00;
    m_sel = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 / R10: reset state and unused addresses
    for (int a = 0; a < 8; a++) rd_chk("R4 R10 reset readback", 3'(a), 8'h00);
    chk("R11 all-zero OTP gives outputs off", outs_off, 1'b1);
    // R2: REG writes do not show while OTP is selected
    m_reg[0] = 8'hA5; m_reg[1] = 8'h3C; m_reg[2] = 8'hC3;
    for (int i = 0; i < 3; i++) wr(3'(i), m_reg[i]);
    chk_view("R2 writes land in REG only");
    // R1 / R11: sweep every select combination
    for (int s = 0; s < 8; s++) begin
      m_sel = 3'(s);
      wr(3'd3, 8'(s));
      chk_view("R1 R11 select sweep");
      rd_chk("R10 command readback", 3'd3, 8'(s));
    end
    for (int a = 4; a < 8; a++) rd_chk("R10 unused address", 3'(a), 8'h00);
    // R3 / R5: shutdown clears selects, writes blocked, REG kept
    @(negedge clk); shutdown = 1'b1;
    wr(3'd0, 8'hFF);
    @(negedge clk); shutdown = 1'b0;
    m_sel = 3'b000;
    rd_chk("R3 shutdown clears command", 3'd3, 8'h00);
    chk_view("R3 OTP after shutdown");
    m_sel = 3'b111; wr(3'd3, 8'h07);
    chk_view("R5 R3 REG kept and shutdown write ignored");
    // R4: lockout clears command
    @(negedge clk); lockout = 1'b1;
    @(negedge clk); lockout = 1'b0;
    m_sel = 3'b000;
    rd_chk("R4 lockout clears command", 3'd3, 8'h00);
    // R6: program request without supply stays pending
    m_reg[0] = 8'h11; m_reg[1] = 8'h22; wr(3'd0, 8'h11); wr(3'd1, 8'h22);
    wr(3'd3, 8'h08);
    repeat (4) @(negedge clk);
    chk("R6 no pulse without supply", pulse_cnt, 0);
    rd_chk("R6 request pending", 3'd3, 8'h08);
    rd_chk("R2 OTP untouched", 3'd0, 8'h00);
    vpp = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 R7 exactly one pulse", pulse_cnt, 1);
    rd_chk("R7 write-OTP bit self-cleared", 3'd3, 8'h00);
    for (int i = 0; i < 3; i++) m_otp[i] = m_reg[i];
    chk_view("R6 OTP took REG");
    // R8: program with burn-lock
    m_reg[0] = 8'h5A; wr(3'd0, 8'h5A);
    m_sel = 3'b111; wr(3'd3, 8'h1F);
    repeat (3) @(negedge clk);
    chk("R8 burn pulse", pulse_cnt, 2);
    rd_chk("R8 lock visible in bit 7", 3'd3, 8'h87);
    for (int i = 0; i < 3; i++) m_otp[i] = m_reg[i];
    wr(3'd0, 8'h99);
    rd_chk("R8 REG write ignored under lock", 3'd0, 8'h5A);
    wr(3'd3, 8'h00);
    rd_chk("R8 select write ignored under lock", 3'd3, 8'h87);
    // R9: switch-off still works, program blocked
    wr(3'd3, 8'h48);
    chk("R9 switch-off under lock", swoff, 1'b1);
    rd_chk("R9 R8 command under lock", 3'd3, 8'hC7);
    repeat (3) @(negedge clk);
    chk("R8 no pulse while locked", pulse_cnt, 2);
    wr(3'd3, 8'h20);
    rd_chk("R9 reset bit under lock", 3'd3, 8'h80);
    chk("R9 switch-off cleared", swoff, 1'b0);
    m_sel = 3'b000;
    chk_view("R9 OTP back in control");
    finish_run();
  end

endmodule